// File: doc/BRIEF.md
# Flag-Addressed Microcode Sequencer

This block is the control unit of a small 8-bit accumulator processor. A micro-step counter moves forward on every falling clock edge. Its value is decoded into one-hot step lines, and step 0 is also driven out as an active-low line. A constant microcode table is indexed by the current opcode, the current step and two stored condition flags. The table's entry, after a fixed polarity correction, forms the control word that the datapath acts on at the next rising edge.

The condition flags are a carry flag and a zero flag. They are captured from the ALU only when the flag-load input is high. The flags are part of the table index, so a conditional jump takes or skips its branch purely through the contents of the table. No separate branch logic is involved. A step-end bit in the control word cuts an instruction short. An instruction that never sets step-end runs all eight steps and then wraps to step 0.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, the next falling edge forces the step to 0, and the next rising edge clears both flags.
- R2: Outside reset, the step increases by one on every falling edge, and step 7 is followed by step 0.
- R3: Exactly one internal step line is active at a time. `step_zero_n_o` is low exactly when the step is 0.
- R4: For every opcode and flag value, step 0 raises control bits 13 (PC out) and 1 (address load). Step 1 raises bits 2 (memory read), 12 (PC increment) and 4 (instruction load).
- R5: The control bits are: 0 halt, 1 address load, 2 memory read, 3 memory write, 4 instruction load, 5 operand out, 6 accumulator load, 7 accumulator out, 8 sum out, 9 subtract, 10 B load, 11 display load, 12 PC increment, 13 PC out, 14 PC load, 15 flag load, 16 step end. The opcodes and their steps 2 and later are:
  - 1 LDA: {5,1}, then {2,6,16}.
  - 2 ADD and 3 SUB: {5,1}, then {2,10}, then {8,6,15,16}. SUB also sets bit 9 in its last step.
  - 4 STA: {5,1}, then {7,3,16}.
  - 5 LDI: {5,6,16}.
  - 6 JMP: {5,14,16}.
  - 14 OUT: {7,11,16}.
  - 15 HLT: {0} at every step from 2 to 7, with no step end.
  - 0 NOP: {16}.
  - Every step that is not listed has no bits set.
- R6: When the control word has the step-end bit (16) set at a falling edge, the step returns to 0 instead of advancing.
- R7: On a rising edge with `flag_ld_i` high, carry takes `alu_carry_i`, and zero takes 1 exactly when `alu_sum_i` is all zeros.
- R8: On a rising edge with `flag_ld_i` low, both flags keep their values, whatever the ALU inputs are.
- R9: Opcode 7 (jump on carry) and opcode 8 (jump on zero) produce {5,14,16} at step 2 when their flag is set, and only {16} when it is clear.
- R10: The table stores every bit active-high. Bits 3 (memory write) and 4 (instruction load) leave the block inverted, as active-low signals. All other bits leave unchanged.
- R11: The unassigned opcodes 9 to 13 behave like NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The step counter uses the falling edge; the flags use the rising edge. |
| rst_n | input | 1 | Synchronous active-low reset. |
| opcode_i | input | 4 | Opcode of the current instruction. |
| alu_carry_i | input | 1 | Carry out of the ALU. |
| alu_sum_i | input | 8 | ALU result, tested for zero. |
| flag_ld_i | input | 1 | Captures the flags on the rising edge when high. |
| ctrl_o | output | 17 | Control word. Bits 3 and 4 are active-low. |
| step_zero_n_o | output | 1 | Low while the step is 0. |

## Verification
The control word and the step-zero line are compared on every cycle against a behavioural model. The model is exercised with four kinds of input:
- Every opcode in turn with the flags still clear after reset. This separates each opcode's micro-sequence, the NOP behaviour of the unassigned codes, and the full eight-step wrap of HLT.
- Flag loads of chosen carry and sum values, each followed by both conditional jumps. This shows whether each flag selects the taken or untaken entry on its own.
- A stretch where the ALU inputs change while the flag load stays low. This shows that the flags are held.
- A long random stream of opcodes, flag loads and ALU values, with a reset asserted in the middle of an instruction.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
// Package: useq_pkg
// Shared constants for the microcode sequencer: control-word bit positions,
// opcode values, output polarity and the function that computes each
// microcode table entry. Assumes 4-bit opcodes and at most 8 micro-steps.
package useq_pkg;

    localparam int CW_W = 17;
    typedef logic [CW_W-1:0] cw_t;

    // control-word bit positions
    localparam int B_HALT     = 0;
    localparam int B_ADDR_LD  = 1;
    localparam int B_MEM_RD   = 2;
    localparam int B_MEM_WR   = 3;
    localparam int B_IR_LD    = 4;
    localparam int B_OPND_RD  = 5;
    localparam int B_ACC_LD   = 6;
    localparam int B_ACC_RD   = 7;
    localparam int B_SUM_RD   = 8;
    localparam int B_SUBTRACT = 9;
    localparam int B_OPB_LD   = 10;
    localparam int B_DISP_LD  = 11;
    localparam int B_PC_INC   = 12;
    localparam int B_PC_RD    = 13;
    localparam int B_PC_LD    = 14;
    localparam int B_FLAG_LD  = 15;
    localparam int B_STEP_END = 16;

    // single-bit masks
    localparam cw_t M_HALT     = cw_t'(1) << B_HALT;
    localparam cw_t M_ADDR_LD  = cw_t'(1) << B_ADDR_LD;
    localparam cw_t M_MEM_RD   = cw_t'(1) << B_MEM_RD;
    localparam cw_t M_MEM_WR   = cw_t'(1) << B_MEM_WR;
    localparam cw_t M_IR_LD    = cw_t'(1) << B_IR_LD;
    localparam cw_t M_OPND_RD  = cw_t'(1) << B_OPND_RD;
    localparam cw_t M_ACC_LD   = cw_t'(1) << B_ACC_LD;
    localparam cw_t M_ACC_RD   = cw_t'(1) << B_ACC_RD;
    localparam cw_t M_SUM_RD   = cw_t'(1) << B_SUM_RD;
    localparam cw_t M_SUBTRACT = cw_t'(1) << B_SUBTRACT;
    localparam cw_t M_OPB_LD   = cw_t'(1) << B_OPB_LD;
    localparam cw_t M_DISP_LD  = cw_t'(1) << B_DISP_LD;
    localparam cw_t M_PC_INC   = cw_t'(1) << B_PC_INC;
    localparam cw_t M_PC_RD    = cw_t'(1) << B_PC_RD;
    localparam cw_t M_PC_LD    = cw_t'(1) << B_PC_LD;
    localparam cw_t M_FLAG_LD  = cw_t'(1) << B_FLAG_LD;
    localparam cw_t M_STEP_END = cw_t'(1) << B_STEP_END;

    // bits that leave the block active-low (R10)
    localparam cw_t CW_LOW_MASK = M_MEM_WR | M_IR_LD;

    // opcode values
    localparam int OP_NOP = 0;
    localparam int OP_LDA = 1;
    localparam int OP_ADD = 2;
    localparam int OP_SUB = 3;
    localparam int OP_STA = 4;
    localparam int OP_LDI = 5;
    localparam int OP_JMP = 6;
    localparam int OP_JC  = 7;
    localparam int OP_JZ  = 8;
    localparam int OP_OUT = 14;
    localparam int OP_HLT = 15;

    // Computes one table entry, all bits active-high, from the opcode, step and flags.
    function automatic cw_t ucode_entry(int op, int st, int c, int z);
        cw_t w;
        w = '0;
        if (st == 0) begin
            w = M_PC_RD | M_ADDR_LD;
        end else if (st == 1) begin
            w = M_MEM_RD | M_IR_LD | M_PC_INC;
        end else begin
            case (op)
                OP_LDA: begin
                    if (st == 2) w = M_OPND_RD | M_ADDR_LD;
                    if (st == 3) w = M_MEM_RD | M_ACC_LD | M_STEP_END;
                end
                OP_ADD, OP_SUB: begin
                    if (st == 2) w = M_OPND_RD | M_ADDR_LD;
                    if (st == 3) w = M_MEM_RD | M_OPB_LD;
                    if (st == 4) w = M_SUM_RD | M_ACC_LD | M_FLAG_LD | M_STEP_END
                                   | ((op == OP_SUB) ? M_SUBTRACT : '0);
                end
                OP_STA: begin
                    if (st == 2) w = M_OPND_RD | M_ADDR_LD;
                    if (st == 3) w = M_ACC_RD | M_MEM_WR | M_STEP_END;
                end
                OP_LDI: if (st == 2) w = M_OPND_RD | M_ACC_LD | M_STEP_END;
                OP_JMP: if (st == 2) w = M_OPND_RD | M_PC_LD | M_STEP_END;
                OP_JC: if (st == 2) w = (c != 0) ? (M_OPND_RD | M_PC_LD | M_STEP_END) : M_STEP_END;
                OP_JZ: if (st == 2) w = (z != 0) ? (M_OPND_RD | M_PC_LD | M_STEP_END) : M_STEP_END;
                OP_OUT: if (st == 2) w = M_ACC_RD | M_DISP_LD | M_STEP_END;
                OP_HLT: w = M_HALT;
                default: if (st == 2) w = M_STEP_END;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_step_ctr.sv
`timescale 1ns/1ps
// Module: useq_step_ctr
// Micro-step counter, clocked on the falling edge so that the control word
// settles before the rising edge the datapath uses. Returns to 0 on reset,
// on an active-low clear request, or after the last step.
// Assumes NSTEPS <= 2**STEP_W.
module useq_step_ctr #(
    parameter int STEP_W = 4,
    parameter int NSTEPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    output logic [STEP_W-1:0] step_o
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEPS - 1);

    // advance, clear or wrap the step on each falling edge
    always_ff @(negedge clk) begin
        if (!rst_n)                        step_o <= '0;
        else if (!clr_n || step_o == LAST) step_o <= '0;
        else                               step_o <= step_o + 1'b1;
    end

    AST_STEP_BOUND: assert property (@(negedge clk) disable iff (!rst_n)
        step_o <= LAST);                                                   // R2
    AST_STEP_ADVANCE: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_n) && $past(step_o) != LAST)
            |-> step_o == $past(step_o) + 1'b1);                           // R2
    AST_STEP_EARLY_END: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr_n)) |-> step_o == '0);                 // R6
endmodule

// File: rtl/useq_step_dec.sv
`timescale 1ns/1ps
// Module: useq_step_dec
// Decodes the step count into one-hot step lines, one per micro-step.
// Purely combinational. Assumes that the count never exceeds NSTEPS-1.
module useq_step_dec #(
    parameter int STEP_W = 4,
    parameter int NSTEPS = 8
) (
    input  logic [STEP_W-1:0] step_i,
    output logic [NSTEPS-1:0] line_o
);
    // one comparator per step line
    for (genvar i = 0; i < NSTEPS; i++) begin : g_line
        assign line_o[i] = (step_i == STEP_W'(i));
    end
endmodule

// File: rtl/useq_flags.sv
`timescale 1ns/1ps
// Module: useq_flags
// Carry and zero flag register. Loads on a rising edge when ld_i is high.
// The zero flag is set when the ALU result is all zeros.
// Cleared by the synchronous active-low reset.
module useq_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              carry_i,
    input  logic [DATA_W-1:0] sum_i,
    output logic              cf_o,
    output logic              zf_o
);
    logic sum_is_zero;

    // detect an all-zero ALU result
    always_comb sum_is_zero = (sum_i == '0);

    // capture the flags on a load, clear them on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cf_o <= 1'b0;
            zf_o <= 1'b0;
        end else if (ld_i) begin
            cf_o <= carry_i;
            zf_o <= sum_is_zero;
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_i)) |-> $stable({cf_o, zf_o}));          // R8
    AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_i)) |-> zf_o == ($past(sum_i) == '0));     // R7
    AST_FLAG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_i)) |-> cf_o == $past(carry_i));           // R7
endmodule

// File: rtl/useq_urom.sv
`timescale 1ns/1ps
// Module: useq_urom
// Constant microcode table indexed by {zero flag, carry flag, opcode, step}.
// Each entry is computed at elaboration by useq_pkg::ucode_entry, with all
// bits active-high. Assumes NSTEPS is a power of two.
module useq_urom
    import useq_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int NSTEPS = 8
) (
    input  logic [OP_W-1:0]           op_i,
    input  logic [$clog2(NSTEPS)-1:0] sel_i,
    input  logic                      cf_i,
    input  logic                      zf_i,
    output cw_t                       cw_o
);
    localparam int SEL_W = $clog2(NSTEPS);
    localparam int AW    = 2 + OP_W + SEL_W;
    localparam int DEPTH = 1 << AW;

    cw_t             tbl [DEPTH];
    logic [AW-1:0]   addr;

    // fill every table entry from the package function
    for (genvar a = 0; a < DEPTH; a++) begin : g_ent
        localparam int STV = a % (1 << SEL_W);
        localparam int OPV = (a >> SEL_W) % (1 << OP_W);
        localparam int CV  = (a >> (SEL_W + OP_W)) % 2;
        localparam int ZV  = (a >> (SEL_W + OP_W + 1)) % 2;
        assign tbl[a] = ucode_entry(OPV, STV, CV, ZV);
    end

    // form the index and read the entry
    always_comb begin
        addr = {zf_i, cf_i, op_i, sel_i};
        cw_o = tbl[addr];
    end
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
// Module: useq_ctrl (top)
// Control unit of a small accumulator CPU. A falling-edge step counter and
// the stored flags index a constant microcode table; the entry is
// polarity-corrected and driven out as the control word. A step-end bit
// in the entry ends the instruction early. Assumes opcode_i holds steady
// from step 2 of an instruction to its end.
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int DATA_W = 8,
    parameter int STEP_W = 4,
    parameter int NSTEPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              alu_carry_i,
    input  logic [DATA_W-1:0] alu_sum_i,
    input  logic              flag_ld_i,
    output logic [CW_W-1:0]   ctrl_o,
    output logic              step_zero_n_o
);
    localparam int SEL_W = $clog2(NSTEPS);

    logic [STEP_W-1:0] step;
    logic [NSTEPS-1:0] step_line;
    logic              flag_c;
    logic              flag_z;
    cw_t               cw_raw;
    logic              step_clr_n;

    useq_step_ctr #(.STEP_W(STEP_W), .NSTEPS(NSTEPS)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (step_clr_n),
        .step_o (step)
    );

    useq_step_dec #(.STEP_W(STEP_W), .NSTEPS(NSTEPS)) u_dec (
        .step_i (step),
        .line_o (step_line)
    );

    useq_flags #(.DATA_W(DATA_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_i    (flag_ld_i),
        .carry_i (alu_carry_i),
        .sum_i   (alu_sum_i),
        .cf_o    (flag_c),
        .zf_o    (flag_z)
    );

    useq_urom #(.OP_W(OP_W), .NSTEPS(NSTEPS)) u_rom (
        .op_i  (opcode_i),
        .sel_i (step[SEL_W-1:0]),
        .cf_i  (flag_c),
        .zf_i  (flag_z),
        .cw_o  (cw_raw)
    );

    // invert the stored step-end bit into the active-low clear request
    always_comb step_clr_n = ~cw_raw[B_STEP_END];

    // apply output polarity and export the step-zero line
    always_comb begin
        ctrl_o        = cw_raw ^ CW_LOW_MASK;
        step_zero_n_o = ~step_line[0];
    end

    AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_line) == 1);                                       // R3
    AST_FETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
        !step_zero_n_o |-> (ctrl_o[B_PC_RD] && ctrl_o[B_ADDR_LD]));         // R4
    AST_IRLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        step_line[1] |-> !ctrl_o[B_IR_LD]);                                // R10
    AST_JC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == OP_W'(OP_JC) && step_line[2] && !flag_c)
            |-> !ctrl_o[B_PC_LD]);                                         // R9
endmodule

// File: tb/useq_ctrl_test.sv
`timescale 1ns/1ps
module useq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic        alu_carry = 1'b0;
    logic [7:0]  alu_sum = 8'd0;
    logic        flag_ld = 1'b0;
    logic [16:0] ctrl;
    logic        step_zero_n;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string ctx = "R1";

    // reference model state
    int m_step = 0;
    bit m_cf = 0;
    bit m_zf = 0;

    always #2.5 clk = ~clk;

    useq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .alu_carry_i(alu_carry),
        .alu_sum_i(alu_sum), .flag_ld_i(flag_ld), .ctrl_o(ctrl),
        .step_zero_n_o(step_zero_n)
    );

    function automatic logic [16:0] bits(input int a, input int b = -1, input int c = -1,
                                         input int d = -1);
        logic [16:0] v = '0;
        v[a] = 1'b1;
        if (b >= 0) v[b] = 1'b1;
        if (c >= 0) v[c] = 1'b1;
        if (d >= 0) v[d] = 1'b1;
        return v;
    endfunction

    // expected active-high word, taken from R4, R5, R9 and R11
    function automatic logic [16:0] expect_raw(input int op, input int st, input bit c, input bit z);
        if (st == 0) return bits(13, 1);
        if (st == 1) return bits(2, 12, 4);
        if (op == 15) return bits(0);
        if (op == 1 && st == 2) return bits(5, 1);
        if (op == 1 && st == 3) return bits(2, 6, 16);
        if ((op == 2 || op == 3) && st == 2) return bits(5, 1);
        if ((op == 2 || op == 3) && st == 3) return bits(2, 10);
        if (op == 2 && st == 4) return bits(8, 6, 15, 16);
        if (op == 3 && st == 4) return bits(8, 6, 15, 16) | bits(9);
        if (op == 4 && st == 2) return bits(5, 1);
        if (op == 4 && st == 3) return bits(7, 3, 16);
        if (op == 5 && st == 2) return bits(5, 6, 16);
        if (op == 6 && st == 2) return bits(5, 14, 16);
        if (op == 7 && st == 2) return c ? bits(5, 14, 16) : bits(16);
        if (op == 8 && st == 2) return z ? bits(5, 14, 16) : bits(16);
        if (op == 14 && st == 2) return bits(7, 11, 16);
        if (st == 2 && op != 14 && op != 15) return bits(16);  // NOP and opcodes 9..13 (R11)
        return '0;
    endfunction

    // R1 R2 R6: step model, on falling edges
    always @(negedge clk) begin
        logic [16:0] w;
        w = expect_raw(int'(opcode), m_step, m_cf, m_zf);
        if (!rst_n)                      m_step = 0;
        else if (w[16] || m_step == 7)   m_step = 0;
        else                             m_step = m_step + 1;
    end

    // R1 R7 R8: flag model, on rising edges
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cf = 0; m_zf = 0;
        end else if (flag_ld) begin
            m_cf = alu_carry; m_zf = (alu_sum == 8'd0);
        end
    end

    task automatic check_now();
        logic [16:0] e;
        logic        ez;
        string       lbl;
        // R10: bits 3 and 4 are inverted at the port
        e  = expect_raw(int'(opcode), m_step, m_cf, m_zf) ^ 17'h00018;
        ez = (m_step != 0);
        if (!rst_n)           lbl = "R1";
        else if (m_step == 0) lbl = {"R3 R4 ", ctx};
        else if (m_step == 1) lbl = {"R4 ", ctx};
        else                  lbl = ctx;
        n_chk++;
        if (ctrl !== e || step_zero_n !== ez) begin
            n_bad++;
            $display("FAIL %s: op=%0d step=%0d ctrl_o=%h step_zero_n=%b expected ctrl_o=%h step_zero_n=%b",
                     lbl, opcode, m_step, ctrl, step_zero_n, e, ez);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        check_now();
    endtask

    // runs one instruction from step 0 back to step 0
    task automatic run_instr(input int op);
        opcode = op[3:0];
        tick();
        for (int k = 0; k < 12 && m_step != 0; k++) tick();
    endtask

    initial begin
        repeat (2) @(posedge clk);
        ctx = "R1";
        repeat (3) tick();                       // R1 reset state
        rst_n = 1'b1;

        // R5 R11 R2 R6: every opcode with clear flags; HLT wraps after step 7
        ctx = "R5 R6 R11 R2";
        for (int op = 0; op < 16; op++) run_instr(op);

        // R10: dedicated polarity check at step 1
        opcode = 4'd5;
        tick();
        n_chk++;
        if (!(ctrl[4] == 1'b0 && ctrl[3] == 1'b1 && ctrl[12] == 1'b1)) begin
            n_bad++;
            $display("FAIL R10: ctrl_o[4:3]=%b expected 01", ctrl[4:3]);
        end
        for (int k = 0; k < 4 && m_step != 0; k++) tick();

        // R7 R9: load carry=1, sum=0; both jumps taken
        ctx = "R7 R9";
        flag_ld = 1'b1; alu_carry = 1'b1; alu_sum = 8'h00;
        tick();
        flag_ld = 1'b0;
        for (int k = 0; k < 8 && m_step != 0; k++) tick();
        run_instr(7);
        run_instr(8);

        // R8: ALU inputs move with flag load low; jumps stay taken
        ctx = "R8 R9";
        alu_carry = 1'b0; alu_sum = 8'h5A;
        run_instr(7);
        alu_sum = 8'h01;
        run_instr(8);

        // R7 R9: carry=0, nonzero sum; neither jump taken
        ctx = "R7 R9";
        flag_ld = 1'b1; alu_carry = 1'b0; alu_sum = 8'h80;
        tick();
        flag_ld = 1'b0;
        for (int k = 0; k < 8 && m_step != 0; k++) tick();
        run_instr(7);
        run_instr(8);

        // R7 R9: carry=1 with nonzero sum; only jump on carry taken
        flag_ld = 1'b1; alu_carry = 1'b1; alu_sum = 8'hFF;
        tick();
        flag_ld = 1'b0;
        for (int k = 0; k < 8 && m_step != 0; k++) tick();
        run_instr(7);
        run_instr(8);

        // R1: reset in the middle of an ADD
        opcode = 4'd2;
        tick(); tick();
        rst_n = 1'b0;
        ctx = "R1";
        tick(); tick();
        rst_n = 1'b1;

        // random stream of opcodes, flag loads and ALU values
        ctx = "R5 R7 R8 R9";
        for (int n = 0; n < 3000; n++) begin
            if (m_step == 0) opcode = 4'($urandom_range(0, 15));
            flag_ld   = 1'($urandom_range(0, 1));
            alu_carry = 1'($urandom_range(0, 1));
            alu_sum   = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
            tick();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule